// File: doc/BRIEF.md
# Lead/Lag Driven Successive-Approximation Trim Sequencer

This block sets a 4-bit trim code for an external DAC. The DAC biases the up-current source of a charge pump, and the trim cancels the pump's up/down mismatch. The block runs on the reference clock. It waits for a lock indication from the main loop, then performs a binary search on the code. The result of each search step comes from the one-bit lead/lag decision of a bang-bang phase detector. Once the search finishes, the block holds the result and raises a completion flag.

The search runs with inverted polarity. The code rests at all ones, which means no trim. Each step clears one trial bit, starting at the most significant bit. A cleared bit pushes the up current higher. If the reference still leads, the trial bit stays cleared. If the reference lags, the trial bit is set back to one. The search advances only on a slow calibration tick, produced once every sixteen reference cycles, so the analog loop has time to settle between decisions. Losing lock at any time, or a synchronous reset, returns the block to its untrimmed starting point.

Top module: `sar_trim_seq`

## Requirements
- R1: A synchronous active-high `rst` forces `trim_code` to 4'b1111 and `cal_done` to 0 on the next clock edge.
- R2: While the synchronized lock is low, the block stays in coarse acquisition. In this mode `trim_code` stays at 4'b1111 and `cal_done` at 0, whatever `lead_in` does.
- R3: `lock_in` and `lead_in` each pass through a two-flop synchronizer. Tracking starts only after lock is seen. The first calibration tick lands on the 19th rising edge after `lock_in` is first sampled high, which is 16 + 3 edges.
- R4: Calibration ticks come every 16 reference cycles. `trim_code` changes only on a tick, or when lock is lost or reset is applied.
- R5: On the first tick, the MSB is cleared as the trial bit, so 1111 becomes 0111. No decision is used on this tick.
- R6: On each later tick, `lead_in` = 1 means the reference leads. The current trial bit stays 0, and the next lower bit is cleared as the new trial (for example 0111 becomes 0011).
- R7: `lead_in` = 0 means the reference lags. The current trial bit is set back to 1, and the next lower bit is cleared (for example 0011 becomes 0101).
- R8: With decisions lead, lag, lead on ticks 2 to 4, the code runs through 1111, 0111, 0011, 0101, 0100.
- R9: The 5th tick resolves the LSB and raises `cal_done` on that same edge. After that, `trim_code` holds its value and `lead_in` is ignored while lock stays high. The final code holds a 1 in each bit whose decision was lag.
- R10: If lock drops in any mode, the block returns to coarse mode on the 3rd edge after `lock_in` is first sampled low. It then reloads 4'b1111, clears `cal_done`, and restarts the divider, so a new lock waits the full 19 edges again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lock indication from the main loop (asynchronous) |
| lead_in | input | 1 | Bang-bang decision: 1 means the reference leads the feedback (asynchronous) |
| trim_code | output | 4 | Trim code to the DAC; 4'b1111 means no trim |
| cal_done | output | 1 | High once the search has ended and the code is held |

## Verification
The hardest case to reach is a decision that must be present at the exact calibration tick. The decision is captured only once every sixteen cycles, and only after two synchronizer stages. A decision presented at the wrong time would be taken for the wrong bit. The bench counts edges from the moment lock is raised. It changes `lead_in` just after each tick, so the value has settled well before the next one. It also checks the code one cycle before each tick, to catch an early change. Lock loss in the middle of a search, and reset while lock stays high, are both followed by a full relock. This shows that the divider restarts from zero.

// File: rtl/sar_trim_pkg.sv
package sar_trim_pkg;
   typedef enum logic [1:0] {
      MODE_COARSE = 2'd0,
      MODE_TRACK  = 2'd1,
      MODE_HOLD   = 2'd2
   } trim_mode_e;
endpackage

// File: rtl/sar_trim_sync.sv
module sar_trim_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sar_trim_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain[0] <= '0;
            else     chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sar_trim_div.sv
module sar_trim_div #(
   parameter int DIV_LOG2 = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic tick
);
   if (DIV_LOG2 < 0) begin : g_bad_div
      $error("sar_trim_div: DIV_LOG2 must not be negative");
   end

   if (DIV_LOG2 == 0) begin : g_every
      assign tick = run;
   end else begin : g_count
      localparam int CW = DIV_LOG2;
      logic [CW-1:0] cnt;

      always_ff @(posedge clk) begin
         if (rst || !run) cnt <= '0;
         else             cnt <= cnt + 1'b1;
      end

      assign tick = run && (cnt == {CW{1'b1}});
   end
endmodule

// File: rtl/sar_trim_core.sv
module sar_trim_core
   import sar_trim_pkg::*;
#(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lock_s,
   input  logic              lead_s,
   input  logic              tick,
   output logic [CODE_W-1:0] code,
   output logic              done,
   output trim_mode_e        mode
);
   localparam int SW = $clog2(CODE_W + 1);

   logic [SW-1:0]     step;
   logic [CODE_W-1:0] code_nx;
   int                trial;

   always_comb begin
      code_nx = code;
      trial   = CODE_W - int'(step);
      if (step == '0) begin
         code_nx[CODE_W-1] = 1'b0;
      end else begin
         for (int i = 0; i < CODE_W; i++) begin
            if (i == trial)     code_nx[i] = ~lead_s;
            if (i == trial - 1) code_nx[i] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst || !lock_s) begin
         mode <= MODE_COARSE;
         code <= '1;
         step <= '0;
         done <= 1'b0;
      end else begin
         case (mode)
            MODE_COARSE: mode <= MODE_TRACK;
            MODE_TRACK: if (tick) begin
               code <= code_nx;
               step <= step + 1'b1;
               if (int'(step) == CODE_W) begin
                  mode <= MODE_HOLD;
                  done <= 1'b1;
               end
            end
            default: mode <= MODE_HOLD;
         endcase
      end
   end
endmodule

// File: rtl/sar_trim_seq.sv
module sar_trim_seq
   import sar_trim_pkg::*;
#(
   parameter int CODE_W      = 4,
   parameter int DIV_LOG2    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              lock_in,
   input  logic              lead_in,
   output logic [CODE_W-1:0] trim_code,
   output logic              cal_done
);
   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
      $error("sar_trim_seq: CODE_W out of range");
   end

   logic [1:0] sync_q;
   logic       lock_q;
   logic       lead_q;
   logic       cal_tick;
   trim_mode_e mode;

   sar_trim_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({lock_in, lead_in}),
      .q   (sync_q)
   );
   assign lock_q = sync_q[1];
   assign lead_q = sync_q[0];

   sar_trim_div #(.DIV_LOG2(DIV_LOG2)) u_div (
      .clk  (clk),
      .rst  (rst),
      .run  (lock_q && (mode == MODE_TRACK)),
      .tick (cal_tick)
   );

   sar_trim_core #(.CODE_W(CODE_W)) u_core (
      .clk    (clk),
      .rst    (rst),
      .lock_s (lock_q),
      .lead_s (lead_q),
      .tick   (cal_tick),
      .code   (trim_code),
      .done   (cal_done),
      .mode   (mode)
   );
endmodule

// File: rtl/sar_trim_seq_chk.sv
module sar_trim_seq_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              lock_s,
   input logic              tick,
   input logic [CODE_W-1:0] trim_code,
   input logic              done
);
   // R1: reset loads the untrimmed code
   p_reset_load_r1: assert property (@(posedge clk)
      rst |=> (trim_code == {CODE_W{1'b1}}) && !done);

   // R2 / R10: missing lock forces coarse state
   p_unlock_coarse_r10: assert property (@(posedge clk) disable iff (rst)
      !lock_s |=> (trim_code == {CODE_W{1'b1}}) && !done);

   // R4: code moves only on a calibration tick
   p_tick_only_r4: assert property (@(posedge clk) disable iff (rst)
      (lock_s && !tick) |=> $stable(trim_code));

   // R6 / R7: one tick changes at most the trial bit and its lower neighbour
   p_step_bits_r6: assert property (@(posedge clk) disable iff (rst)
      (lock_s && tick) |=> ($countones(trim_code ^ $past(trim_code)) <= 2));

   // R9: completion is sticky and the code is frozen while lock holds
   p_hold_done_r9: assert property (@(posedge clk) disable iff (rst)
      (done && lock_s) |=> done && $stable(trim_code));
endmodule

bind sar_trim_seq sar_trim_seq_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .lock_s    (lock_q),
   .tick      (cal_tick),
   .trim_code (trim_code),
   .done      (cal_done)
);

// File: tb/sar_trim_seq_test.sv
`timescale 1ns/1ps
module sar_trim_seq_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       lock_in = 1'b0;
   logic       lead_in = 1'b0;
   logic [3:0] trim_code;
   logic       cal_done;

   int n_checks = 0;
   int n_fail   = 0;

   always #2 clk = ~clk;

   sar_trim_seq uut (
      .clk       (clk),
      .rst       (rst),
      .lock_in   (lock_in),
      .lead_in   (lead_in),
      .trim_code (trim_code),
      .cal_done  (cal_done)
   );

   // decisions for bits 3..0 (1 = reference leads)
   localparam logic [3:0] PATTERNS [5] = '{4'b1010, 4'b0000, 4'b1111, 4'b0110, 4'b1001};

   task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // starts at a negedge with lock low and the code untrimmed
   task automatic run_search(input logic [3:0] dec, input bit abort_after_t2);
      logic [3:0] exp;
      exp = 4'b1111;
      lock_in = 1'b1;
      lead_in = dec[3];
      edges(18);
      chk("R3 no tick before 19th edge", trim_code, 4'b1111);
      edges(1);
      exp[3] = 1'b0;
      chk("R5 first tick clears MSB", trim_code, exp);
      chk("R9 done low during search", {3'b0, cal_done}, 4'b0);
      for (int k = 2; k <= 5; k++) begin
         int idx;
         idx = 5 - k;
         edges(15);
         chk("R4 code steady between ticks", trim_code, exp);
         edges(1);
         exp[idx] = ~dec[idx];
         if (idx > 0) exp[idx-1] = 1'b0;
         chk(dec[idx] ? "R6 lead keeps trial bit" : "R7 lag restores trial bit", trim_code, exp);
         chk("R9 done flag timing", {3'b0, cal_done}, {3'b0, (k == 5)});
         if (k < 5) lead_in = dec[4-k];
         if (abort_after_t2 && k == 2) begin
            lock_in = 1'b0;
            edges(2);
            chk("R10 code kept until 3rd edge", trim_code, exp);
            edges(1);
            chk("R10 lock loss reloads code", trim_code, 4'b1111);
            return;
         end
      end
      chk("R9 final code is inverted decisions", trim_code, ~dec);
      for (int c = 0; c < 40; c++) begin
         lead_in = ~lead_in;
         edges(1);
      end
      chk("R9 code held after done", trim_code, ~dec);
      chk("R9 done stays high", {3'b0, cal_done}, 4'b1);
      lock_in = 1'b0;
      edges(2);
      chk("R10 hold kept until 3rd edge", trim_code, ~dec);
      edges(1);
      chk("R10 lock loss from hold", trim_code, 4'b1111);
      chk("R10 done cleared", {3'b0, cal_done}, 4'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      edges(3);
      chk("R1 reset code", trim_code, 4'b1111);
      chk("R1 reset done", {3'b0, cal_done}, 4'b0);
      rst = 1'b0;

      // R2: coarse mode ignores the decision input
      for (int c = 0; c < 50; c++) begin
         lead_in = c[0];
         edges(1);
      end
      chk("R2 coarse holds code", trim_code, 4'b1111);
      chk("R2 coarse done low", {3'b0, cal_done}, 4'b0);

      // R8: worked sequence, then the other patterns from the table
      for (int p = 0; p < 5; p++) run_search(PATTERNS[p], 1'b0);

      // R10: lock loss mid-search, then full relock with divider restart
      run_search(4'b1100, 1'b1);
      edges(4);
      run_search(4'b0101, 1'b0);

      // R1: reset mid-search with lock kept high
      lock_in = 1'b1;
      lead_in = 1'b1;
      edges(40);
      rst = 1'b1;
      edges(1);
      chk("R1 reset mid-search code", trim_code, 4'b1111);
      chk("R1 reset mid-search done", {3'b0, cal_done}, 4'b0);
      rst = 1'b0;
      edges(18);
      chk("R3 relock after reset waits", trim_code, 4'b1111);
      edges(1);
      chk("R3 first tick after reset", trim_code, 4'b0111);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule